// File: doc/BRIEF.md
# ADC Conversion Timing Generator

This block sets the timing of one analog-to-digital conversion. It divides the system clock by a programmable even factor to make a converter clock. For each conversion it then drives the phase signals for the analog front end and the successive-approximation logic. A sequencer asks for a conversion with a one-cycle start request. The block holds a sample-enable for a selectable number of converter clocks. It then issues one bit-decision strobe every two converter clocks, with a bit index that counts from the most significant bit down. It ends the conversion with a one-cycle done pulse. The sampling switch and the comparator live outside the block.

Two fields configure the block. The first is a 5-bit prescaler code. The second is a 2-bit sample-length select. Both are captured when a conversion starts, so a change made in the middle of a conversion waits for the next one. Some prescaler codes have no defined clock. When one of these is captured, the block raises an error flag and falls back to the fastest legal divider, so the converter clock is never left undefined.

Top module: `adc_timing_gen`

## Requirements
- R1: For a captured prescaler code c with bit 3 clear, the converter clock period is 2×(c+1) system clocks. `conv_tick` is high for exactly one system cycle at the end of each converter clock period. The first tick comes 2×(c+1) cycles after the start is accepted.
- R2: A captured prescaler code with bit 3 set is reserved (patterns 01xxx and 11xxx). It sets `cfg_err` from the cycle after acceptance, and the conversion then runs with a divide of 2. A legal code clears `cfg_err` in the same way. `cfg_err` is low after reset.
- R3: The sample select s (0..3) sets the sample phase to 2, 4, 8 or 16 converter clocks, which is 2<<s. `sample_en` is high from the cycle after acceptance until the end of that many converter clocks.
- R4: The approximation phase lasts 16 converter clocks and follows the sample phase. In it, `bit_stb` pulses for one cycle at the end of every second converter clock, eight times in all. `bit_idx` reads 7, 6, ..., 0 on those pulses, most significant bit first.
- R5: A conversion lasts (2<<s)+16 converter clocks, which is 18, 20, 24 or 32. `done_pulse` is high for one cycle, in the same cycle as the last bit strobe. At that point `busy` has already dropped, so a new start may be accepted in that cycle.
- R6: A start request that arrives while `busy` is high is ignored. The running conversion keeps its timing.
- R7: Changes to the prescaler or sample-select inputs during a conversion have no effect on that conversion. They take effect only when the next start is accepted.
- R8: During and just after reset, `busy`, `sample_en`, `bit_stb`, `done_pulse`, `conv_tick`, `conv_clk` and `cfg_err` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| presc_code | input | 5 | Prescaler code, captured at start |
| smp_sel | input | 2 | Sample-length select, captured at start |
| start_req | input | 1 | Conversion request from the sequencer |
| conv_tick | output | 1 | One-cycle pulse at the end of each converter clock |
| conv_clk | output | 1 | Converter clock, 50% duty, low while idle |
| sample_en | output | 1 | High during the sample phase |
| bit_stb | output | 1 | Bit-decision strobe |
| bit_idx | output | 3 | Bit index that goes with `bit_stb` |
| done_pulse | output | 1 | One-cycle end-of-conversion pulse |
| busy | output | 1 | A conversion is running |
| cfg_err | output | 1 | The captured prescaler code was reserved |

## Verification
The bench uses the default parameters: a 5-bit prescaler, a 2-bit sample select and eight bit steps. With these widths it can run one conversion for every one of the 32 prescaler codes, legal and reserved, and one for every sample length. The longest conversion is 32 converter clocks of 48 system cycles each, so the sweep stays short. In every conversion the bench checks the exact cycle of each tick, strobe and done pulse against values it works out itself. Two further runs change the configuration inputs and raise a start request in the middle of a conversion.

// File: rtl/adc_tim_pkg.sv
// Package: adc_tim_pkg
// Holds the shared widths of the conversion timing generator. Nothing here is
// state; the modules take these values as parameter defaults.
package adc_tim_pkg;
    parameter int PRESC_W   = 5;  // prescaler code width
    parameter int SMP_W     = 2;  // sample-length select width
    parameter int BIT_STEPS = 8;  // bit decisions per conversion
endpackage

// File: rtl/adc_cfg_latch.sv
// Module: adc_cfg_latch
// Decodes the prescaler code and the sample select, and captures them when
// load is high. Assumes that load only rises when the sequencer accepts a
// start, so the captured values stay fixed for the whole conversion.
module adc_cfg_latch #(
    parameter int PRESC_W = adc_tim_pkg::PRESC_W,
    parameter int SMP_W   = adc_tim_pkg::SMP_W,
    parameter int CNT_W   = 6,
    localparam int DIV_W  = PRESC_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               load,
    input  logic [PRESC_W-1:0] presc_code,
    input  logic [SMP_W-1:0]   smp_sel,
    output logic [DIV_W-1:0]   div_m1,
    output logic [CNT_W-1:0]   smp_len,
    output logic               cfg_err
);
    logic             reserved;
    logic [DIV_W-1:0] div_m1_nxt;

    // Codes with bit 3 set have no defined divider.
    always_comb reserved = presc_code[3];

    // Divide by 2*(c+1) means a terminal count of 2c+1; reserved codes fall back to 1.
    always_comb div_m1_nxt = reserved ? DIV_W'(1) : {presc_code, 1'b1};

    // Capture the decoded configuration at the start of a conversion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            div_m1  <= DIV_W'(1);
            smp_len <= CNT_W'(2);
            cfg_err <= 1'b0;
        end else if (load) begin
            div_m1  <= div_m1_nxt;
            smp_len <= CNT_W'(2) << smp_sel;
            cfg_err <= reserved;
        end
    end
endmodule

// File: rtl/adc_presc_div.sv
// Module: adc_presc_div
// Divides the system clock by the captured even factor while a conversion is
// running. Gives a one-cycle tick at the end of each converter clock and a
// 50% converter clock. Assumes div_m1 is odd and at least 1.
module adc_presc_div #(
    parameter int DIV_W = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div_m1,
    output logic             tick,
    output logic             cclk
);
    logic [DIV_W-1:0] cnt;

    // Count system cycles within a converter clock; hold at zero while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run)    cnt <= '0;
        else if (cnt == div_m1) cnt <= '0;
        else                    cnt <= cnt + DIV_W'(1);
    end

    // Tick in the last cycle of the period.
    always_comb tick = run && (cnt == div_m1);

    // The second half of the period is high, so the falling edge lines up with the tick.
    always_comb cclk = run && (cnt > (div_m1 >> 1));
endmodule

// File: rtl/adc_phase_seq.sv
// Module: adc_phase_seq
// Counts converter clocks through the sample and approximation phases. Drives
// busy, sample enable, the bit strobes and the done pulse. Assumes smp_len is
// stable while busy is high.
module adc_phase_seq #(
    parameter int BIT_STEPS = adc_tim_pkg::BIT_STEPS,
    parameter int CNT_W     = 6,
    localparam int IDX_W    = $clog2(BIT_STEPS),
    localparam int APPR_LEN = 2 * BIT_STEPS
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_req,
    input  logic             tick,
    input  logic [CNT_W-1:0] smp_len,
    output logic             accept,
    output logic             busy,
    output logic             sample_en,
    output logic             bit_stb,
    output logic [IDX_W-1:0] bit_idx,
    output logic             done_pulse
);
    logic [CNT_W-1:0] ccnt;
    logic [CNT_W-1:0] nxt;
    logic [CNT_W-1:0] appr;
    logic [CNT_W-1:0] step;
    logic             last;

    // A start is taken only while idle.
    always_comb accept = start_req && !busy;

    // Decode the converter clock that ends with the current tick.
    always_comb begin
        nxt  = ccnt + CNT_W'(1);
        appr = nxt - smp_len;
        step = CNT_W'(BIT_STEPS) - (appr >> 1);
        last = (nxt == smp_len + CNT_W'(APPR_LEN));
    end

    // The phase counter and the busy state.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ccnt <= '0;
        end else if (accept) begin
            busy <= 1'b1;
            ccnt <= '0;
        end else if (busy && tick) begin
            ccnt <= nxt;
            if (last) busy <= 1'b0;
        end
    end

    // The strobes are registered, so each is a clean one-cycle pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bit_stb    <= 1'b0;
            bit_idx    <= '0;
            done_pulse <= 1'b0;
        end else begin
            bit_stb    <= busy && tick && (nxt > smp_len) && !appr[0];
            done_pulse <= busy && tick && last;
            if (busy && tick && (nxt > smp_len) && !appr[0])
                bit_idx <= step[IDX_W-1:0];
        end
    end

    // Sampling lasts until smp_len converter clocks have passed.
    always_comb sample_en = busy && (ccnt < smp_len);
endmodule

// File: rtl/adc_timing_gen.sv
// Module: adc_timing_gen
// Top of the conversion timing generator. Captures the configuration when a
// start is accepted, runs the divider while busy, and sequences the phases.
// Assumes start_req comes from a synchronous sequencer in the same clock domain.
module adc_timing_gen #(
    parameter int PRESC_W   = adc_tim_pkg::PRESC_W,
    parameter int SMP_W     = adc_tim_pkg::SMP_W,
    parameter int BIT_STEPS = adc_tim_pkg::BIT_STEPS,
    localparam int DIV_W    = PRESC_W + 1,
    localparam int SMP_MAX  = 2 << ((1 << SMP_W) - 1),
    localparam int CNT_W    = $clog2(SMP_MAX + 2 * BIT_STEPS + 1),
    localparam int IDX_W    = $clog2(BIT_STEPS)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [PRESC_W-1:0] presc_code,
    input  logic [SMP_W-1:0]   smp_sel,
    input  logic               start_req,
    output logic               conv_tick,
    output logic               conv_clk,
    output logic               sample_en,
    output logic               bit_stb,
    output logic [IDX_W-1:0]   bit_idx,
    output logic               done_pulse,
    output logic               busy,
    output logic               cfg_err
);
    logic             accept;
    logic [DIV_W-1:0] div_m1;
    logic [CNT_W-1:0] smp_len;

    adc_cfg_latch #(.PRESC_W(PRESC_W), .SMP_W(SMP_W), .CNT_W(CNT_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .load(accept),
        .presc_code(presc_code), .smp_sel(smp_sel),
        .div_m1(div_m1), .smp_len(smp_len), .cfg_err(cfg_err)
    );

    adc_presc_div #(.DIV_W(DIV_W)) u_div (
        .clk(clk), .rst_n(rst_n), .run(busy), .div_m1(div_m1),
        .tick(conv_tick), .cclk(conv_clk)
    );

    adc_phase_seq #(.BIT_STEPS(BIT_STEPS), .CNT_W(CNT_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .start_req(start_req), .tick(conv_tick),
        .smp_len(smp_len), .accept(accept), .busy(busy),
        .sample_en(sample_en), .bit_stb(bit_stb), .bit_idx(bit_idx),
        .done_pulse(done_pulse)
    );
endmodule

// File: rtl/adc_timing_gen_chk.sv
// Module: adc_timing_gen_chk
// Temporal checks on the ports of adc_timing_gen, bound to every instance.
module adc_timing_gen_chk (
    input logic clk,
    input logic rst_n,
    input logic start_req,
    input logic conv_tick,
    input logic sample_en,
    input logic bit_stb,
    input logic done_pulse,
    input logic busy,
    input logic cfg_err
);
    // R1
    tick_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        conv_tick |=> !conv_tick);
    // R4
    strobe_after_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_stb |-> !sample_en);
    // R5
    done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |-> (bit_stb && !sample_en));
    // R5
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_pulse |=> !done_pulse);
    // R6
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start_req));
    // R7
    err_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg_err));
    // R3
    sample_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(sample_en) && busy) |-> $past(conv_tick));
endmodule

bind adc_timing_gen adc_timing_gen_chk u_chk (.*);

// File: tb/adc_timing_gen_test.sv
module adc_timing_gen_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [4:0] presc_code = '0;
    logic [1:0] smp_sel = '0;
    logic       start_req = 1'b0;
    logic       conv_tick, conv_clk, sample_en, bit_stb, done_pulse, busy, cfg_err;
    logic [2:0] bit_idx;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit finished = 1'b0;

    adc_timing_gen uut (
        .clk(clk), .rst_n(rst_n), .presc_code(presc_code), .smp_sel(smp_sel),
        .start_req(start_req), .conv_tick(conv_tick), .conv_clk(conv_clk),
        .sample_en(sample_en), .bit_stb(bit_stb), .bit_idx(bit_idx),
        .done_pulse(done_pulse), .busy(busy), .cfg_err(cfg_err)
    );

    always #4 clk = ~clk;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 190000) begin
            chk(1'b0, "watchdog", cycles, 190000);
            finish_run();
        end
    end

    // One conversion. With disturb set, the configuration inputs are changed and
    // start is raised again in the middle of the run (R6, R7).
    task automatic run_conv(input logic [4:0] code, input logic [1:0] smp, input bit disturb);
        int div   = code[3] ? 2 : 2 * (code + 1);
        int s     = 2 << smp;
        int total = s + 16;
        int ticks = 0, samp = 0, stb = 0, dones = 0, n = 1;
        @(negedge clk);
        presc_code = code; smp_sel = smp; start_req = 1'b1;
        @(negedge clk);
        start_req = 1'b0;
        // R2: the flag follows the captured code
        chk(cfg_err == code[3], "R2 cfg_err", cfg_err, code[3]);
        while (n <= total * div + 2) begin
            if (disturb && n == 5) begin
                start_req = 1'b1; presc_code = 5'd1; smp_sel = ~smp;
            end
            if (disturb && n == 6) start_req = 1'b0;
            if (conv_tick) begin
                ticks++;
                // R1: ticks every div cycles
                chk(n % div == 0, "R1 tick phase", n, (n / div) * div);
            end
            if (sample_en) samp++;
            if (bit_stb) begin
                stb++;
                // R4: strobe position and MSB-first index
                chk(n == (s + 2 * stb) * div + 1, "R4 strobe cycle", n, (s + 2 * stb) * div + 1);
                chk(int'(bit_idx) == 8 - stb, "R4 bit index", bit_idx, 8 - stb);
            end
            if (done_pulse) begin
                dones++;
                // R5 (R6/R7 under disturb): done at the expected cycle, idle afterwards
                chk(n == total * div + 1, "R5 done cycle", n, total * div + 1);
                chk(!busy, "R5 busy low at done", busy, 0);
            end
            if (disturb && n > 1 && n <= total * div)
                chk(cfg_err == code[3], "R7 cfg_err stable", cfg_err, code[3]);
            @(negedge clk);
            n++;
        end
        chk(ticks == total, "R1 tick count", ticks, total);
        chk(samp == s * div, "R3 sample cycles", samp, s * div);
        chk(stb == 8, "R4 strobe count", stb, 8);
        chk(dones == 1, "R5 done count", dones, 1);
        chk(!busy, "R6 idle after run", busy, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk(!busy && !sample_en && !bit_stb && !done_pulse, "R8 reset outputs", busy, 0);
        chk(!conv_tick && !conv_clk && !cfg_err, "R8 reset clock/flag", cfg_err, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!busy && !cfg_err && !conv_clk, "R8 after release", busy, 0);
        // All prescaler codes at the shortest sample length (R1, R2)
        for (int c = 0; c < 32; c++) run_conv(5'(c), 2'd0, 1'b0);
        // All sample lengths at two dividers (R3, R5)
        for (int s = 0; s < 4; s++) run_conv(5'd0, 2'(s), 1'b0);
        for (int s = 0; s < 4; s++) run_conv(5'd3, 2'(s), 1'b0);
        // Mid-conversion disturbance (R6, R7)
        run_conv(5'd2, 2'd1, 1'b1);
        run_conv(5'd9, 2'd3, 1'b1);
        finish_run();
    end
endmodule